// File: doc/BRIEF.md
# Port Link Status Monitor

This block tracks the carrier state of a small set of switch ports by polling each port's status word. A pulse on `scan_start` begins one pass. The pass visits every populated port in ascending index order. For a port that is administratively up, the block issues a read of register 0 in that port's register space over a valid/ready request channel. It then waits for a single-beat response and decodes the link, speed, duplex and flow-control fields. A port that is administratively down is taken as link down and is never read.

The block holds one carrier bit per port. An event is emitted only when the observed link differs from the stored carrier. Up events carry the decoded speed code, duplex and flow-control bits. A response flagged as an error leaves that port untouched and the pass moves on.

Events leave on a valid/ready stream. While `evt_valid` is high and `evt_ready` is low, the event is held and the pass is stalled. The request channel follows the same rule: `req_valid` stays up, with a fixed port, until `req_ready` is seen. Only one request is ever outstanding. A response is a one-cycle `rsp_valid` pulse, and it is taken only while `rsp_ready` is high. The port masks must stay stable while `busy` is high.

Top module: `link_monitor`

## Requirements
- R1: After reset every carrier bit is 0, and `busy`, `req_valid` and `evt_valid` are low.
- R2: A pulse on `scan_start` while idle starts one pass. The pass visits the populated ports (`port_present` bit set) in ascending index order, visits each once, and then returns idle with `busy` low. A pulse while busy is ignored.
- R3: A status read for port p is presented as `req_port` = p and `req_reg` = 0. It is held stable until `req_ready` accepts it.
- R4: A populated port whose `port_admin_up` bit is 0 is never read and is treated as link down.
- R5: Link is up when bit 11 of `rsp_data` is 1.
- R6: Bits 9:8 of `rsp_data` form the speed code, which is reported unchanged on up events: 0 means 10 Mb/s, 1 means 100 Mb/s, 2 means 1000 Mb/s and 3 means unknown.
- R7: On up events, `evt_duplex` is bit 10 (full duplex) and `evt_fc` is bit 15 (flow control on). Down events carry 0 in the speed, duplex and flow-control fields.
- R8: A response with `rsp_error` high causes no event and leaves that port's carrier bit unchanged.
- R9: A down event (`evt_up` = 0) is emitted only if the carrier was 1, and an up event only if it was 0. No event is emitted when the link matches the carrier.
- R10: An event's fields are held stable while it waits for `evt_ready`. The port's carrier bit changes exactly at the cycle in which the event is accepted, and at no other time.
- R11: At most one read is outstanding. `req_valid` and `rsp_ready` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_start | input | 1 | Pulse that begins one pass |
| port_present | input | NPORTS | Populated-port mask |
| port_admin_up | input | NPORTS | Administratively-up mask |
| req_valid | output | 1 | Status read request valid |
| req_ready | input | 1 | Request accepted |
| req_port | output | PW | Port whose register space is read |
| req_reg | output | 5 | Register index, always 0 |
| rsp_valid | input | 1 | One-cycle response strobe |
| rsp_ready | output | 1 | Block is waiting for a response |
| rsp_error | input | 1 | The read failed |
| rsp_data | input | 16 | Status word |
| evt_valid | output | 1 | Carrier event valid |
| evt_ready | input | 1 | Event accepted |
| evt_port | output | PW | Port of the event |
| evt_up | output | 1 | 1 = carrier on, 0 = carrier off |
| evt_speed | output | 2 | Speed code (R6) |
| evt_duplex | output | 1 | Full duplex |
| evt_fc | output | 1 | Flow control enabled |
| carrier | output | NPORTS | Current carrier state per port |
| busy | output | 1 | A pass is in progress |

## Verification
The bench sweeps many mask, status-word and error combinations across several consecutive passes, so carrier state carries over from one pass to the next. It also stalls the event stream in a fixed pattern.

Each design fault leaves a distinct trace:
- Reading the wrong bit for link, speed, duplex or flow control shows up as a wrong event field, or as a missing event.
- Reading a port that is administratively down, or letting an error response change the carrier, shows up as a spurious event or a carrier bit that differs from the model.
- Emitting events without comparing against the carrier produces repeated events on later passes.
- Visiting ports out of order, or visiting an unpopulated port, breaks the order of the recorded events.

// File: rtl/lm_pkg.sv
package lm_pkg;
  localparam int LINK_BIT   = 11;
  localparam int DUPLEX_BIT = 10;
  localparam int FC_BIT     = 15;
  localparam int SPEED_LSB  = 8;
  localparam logic [4:0] STATUS_REG = 5'd0;

  typedef enum logic [2:0] {
    S_IDLE, S_SEL, S_REQ, S_WAIT, S_EVT
  } lm_state_t;

  typedef struct packed {
    logic       link;
    logic [1:0] speed;
    logic       duplex;
    logic       fc;
  } lm_status_t;
endpackage

// File: rtl/lm_status_decode.sv
module lm_status_decode
  import lm_pkg::*;
(
  input  logic [15:0] word,
  output lm_status_t  fields
);
  always_comb begin
    fields.link   = word[LINK_BIT];
    fields.speed  = word[SPEED_LSB+1:SPEED_LSB];
    fields.duplex = word[DUPLEX_BIT];
    fields.fc     = word[FC_BIT];
  end
endmodule

// File: rtl/lm_next_port.sv
module lm_next_port #(
  parameter int NPORTS = 4,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic [NPORTS-1:0] present,
  input  logic [PW-1:0]     from_idx,
  output logic              found,
  output logic [PW-1:0]     idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NPORTS - 1; i >= 0; i--) begin
      if (present[i] && (i >= int'(from_idx))) begin
        found = 1'b1;
        idx   = PW'(i);
      end
    end
  end
endmodule

// File: rtl/lm_carrier_bank.sv
module lm_carrier_bank #(
  parameter int NPORTS = 4,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [PW-1:0]     upd_port,
  input  logic              upd_val,
  output logic [NPORTS-1:0] carrier
);
  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n)
        carrier[g] <= 1'b0;
      else if (upd_en && (upd_port == PW'(g)))
        carrier[g] <= upd_val;
    end
  end
endmodule

// File: rtl/link_monitor.sv
module link_monitor
  import lm_pkg::*;
#(
  parameter int NPORTS = 4,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_start,
  input  logic [NPORTS-1:0] port_present,
  input  logic [NPORTS-1:0] port_admin_up,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [PW-1:0]     req_port,
  output logic [4:0]        req_reg,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic              rsp_error,
  input  logic [15:0]       rsp_data,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [PW-1:0]     evt_port,
  output logic              evt_up,
  output logic [1:0]        evt_speed,
  output logic              evt_duplex,
  output logic              evt_fc,
  output logic [NPORTS-1:0] carrier,
  output logic              busy
);
  lm_state_t  state;
  logic [PW-1:0] scan_idx;
  logic [PW-1:0] cur_port;
  logic          nxt_found;
  logic [PW-1:0] nxt_port;
  lm_status_t    dec;
  lm_status_t    ev_fields;
  logic          accept_evt;

  lm_next_port #(.NPORTS(NPORTS)) u_next (
    .present  (port_present),
    .from_idx (scan_idx),
    .found    (nxt_found),
    .idx      (nxt_port)
  );

  lm_status_decode u_dec (
    .word   (rsp_data),
    .fields (dec)
  );

  assign accept_evt = (state == S_EVT) && evt_ready;

  lm_carrier_bank #(.NPORTS(NPORTS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (accept_evt),
    .upd_port (cur_port),
    .upd_val  (ev_fields.link),
    .carrier  (carrier)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      scan_idx  <= '0;
      cur_port  <= '0;
      ev_fields <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (scan_start) begin
            scan_idx <= '0;
            state    <= S_SEL;
          end
        end
        S_SEL: begin
          if (!nxt_found) begin
            state <= S_IDLE;
          end else begin
            cur_port <= nxt_port;
            if (port_admin_up[nxt_port]) begin
              state <= S_REQ;
            end else if (carrier[nxt_port]) begin
              ev_fields <= '0;
              state     <= S_EVT;
            end else if (nxt_port == PW'(NPORTS - 1)) begin
              state <= S_IDLE;
            end else begin
              scan_idx <= nxt_port + PW'(1);
            end
          end
        end
        S_REQ: begin
          if (req_ready) state <= S_WAIT;
        end
        S_WAIT: begin
          if (rsp_valid) begin
            if (!rsp_error && (dec.link != carrier[cur_port])) begin
              ev_fields <= dec.link ? dec : '0;
              state     <= S_EVT;
            end else if (cur_port == PW'(NPORTS - 1)) begin
              state <= S_IDLE;
            end else begin
              scan_idx <= cur_port + PW'(1);
              state    <= S_SEL;
            end
          end
        end
        S_EVT: begin
          if (evt_ready) begin
            if (cur_port == PW'(NPORTS - 1)) begin
              state <= S_IDLE;
            end else begin
              scan_idx <= cur_port + PW'(1);
              state    <= S_SEL;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign req_valid  = (state == S_REQ);
  assign req_port   = cur_port;
  assign req_reg    = STATUS_REG;
  assign rsp_ready  = (state == S_WAIT);
  assign evt_valid  = (state == S_EVT);
  assign evt_port   = cur_port;
  assign evt_up     = ev_fields.link;
  assign evt_speed  = ev_fields.speed;
  assign evt_duplex = ev_fields.duplex;
  assign evt_fc     = ev_fields.fc;
endmodule

// File: rtl/lm_checker.sv
module lm_checker #(
  parameter int NPORTS = 4,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORTS-1:0] port_admin_up,
  input logic              req_valid,
  input logic              req_ready,
  input logic [PW-1:0]     req_port,
  input logic [4:0]        req_reg,
  input logic              rsp_ready,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic [PW-1:0]     evt_port,
  input logic              evt_up,
  input logic [1:0]        evt_speed,
  input logic              evt_duplex,
  input logic              evt_fc,
  input logic [NPORTS-1:0] carrier
);
  // R3: register 0 is always the one read
  a_r3_reg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_reg == 5'd0));

  // R3: request held until accepted
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_port)));

  // R4: no read of an administratively down port
  a_r4_no_read_down: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> port_admin_up[req_port]);

  // R7: down events carry zero fields
  a_r7_down_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_up) |-> (evt_speed == 2'd0 && !evt_duplex && !evt_fc));

  // R9: an event always flips the stored carrier
  a_r9_flip_only: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_up != carrier[evt_port]));

  // R10: event fields held while stalled
  a_r10_evt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable({evt_port, evt_up, evt_speed, evt_duplex, evt_fc})));

  // R10: carrier changes only on an accepted event
  a_r10_carrier_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier != $past(carrier)) |-> $past(evt_valid && evt_ready));

  // R11: one outstanding read
  a_r11_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));
endmodule

bind link_monitor lm_checker #(.NPORTS(NPORTS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .port_admin_up (port_admin_up),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_port      (req_port),
  .req_reg       (req_reg),
  .rsp_ready     (rsp_ready),
  .evt_valid     (evt_valid),
  .evt_ready     (evt_ready),
  .evt_port      (evt_port),
  .evt_up        (evt_up),
  .evt_speed     (evt_speed),
  .evt_duplex    (evt_duplex),
  .evt_fc        (evt_fc),
  .carrier       (carrier)
);

// File: tb/link_monitor_test.sv
module link_monitor_test;
  localparam int N  = 4;
  localparam int PW = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic scan_start = 0;
  logic [N-1:0] port_present = '0;
  logic [N-1:0] port_admin_up = '0;
  logic req_valid, rsp_ready, evt_valid, evt_up, evt_duplex, evt_fc, busy;
  logic req_ready = 1;
  logic rsp_valid = 0;
  logic rsp_error = 0;
  logic [15:0] rsp_data = '0;
  logic evt_ready = 1;
  logic [PW-1:0] req_port, evt_port;
  logic [4:0] req_reg;
  logic [1:0] evt_speed;
  logic [N-1:0] carrier;

  link_monitor #(.NPORTS(N)) uut (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [15:0] st_word [N];
  logic        st_err  [N];
  logic [N-1:0] mdl_car = '0;

  int rec_n = 0;
  logic [PW-1:0] rec_port [64];
  logic [4:0]    rec_bits [64];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // responder: one-cycle response one cycle after acceptance
  initial begin
    forever begin
      @(negedge clk);
      if (req_valid && req_ready && rst_n) begin
        logic [PW-1:0] p;
        p = req_port;
        @(negedge clk);
        rsp_valid = 1;
        rsp_data  = st_word[p];
        rsp_error = st_err[p];
        @(negedge clk);
        rsp_valid = 0;
        rsp_error = 0;
      end
    end
  end

  // event sink with a fixed stall pattern
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      evt_ready = (cyc % 3) != 0;
      if (evt_valid && evt_ready && rec_n < 64) begin
        rec_port[rec_n] = evt_port;
        rec_bits[rec_n] = {evt_up, evt_speed, evt_duplex, evt_fc};
        rec_n++;
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic run_scan();
    @(negedge clk);
    scan_start = 1;
    @(negedge clk);
    scan_start = 0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 carrier", carrier, 0);
    check("R1 busy", busy, 0);
    check("R1 req_valid", req_valid, 0);
    check("R1 evt_valid", evt_valid, 0);
    rst_n = 1;
    @(negedge clk);

    for (int s = 0; s < 24; s++) begin
      int base;
      int ne;
      logic [PW-1:0] ep [8];
      logic [4:0]    eb [8];
      port_present  = (s % 5 == 0) ? 4'b1011 : 4'b1111;
      port_admin_up = (s % 4 == 3) ? 4'b0101 : 4'b1111;
      for (int p = 0; p < N; p++) begin
        logic lk;
        lk = (s < 2) ? (s == 0) : (((s + p) % 3) != 0);
        st_word[p] = 16'(((s * 7 + p * 13) & 8'hff))
                   | 16'(((s + p) % 4) << 8)
                   | 16'((((s >> 1) ^ p) & 1) << 10)
                   | 16'(lk << 11)
                   | 16'((((s + 2 * p) >> 1) & 1) << 15);
        st_err[p] = (s % 6 == 5) && (p == 2);
      end
      // expected events from the requirements
      ne = 0;
      for (int p = 0; p < N; p++) begin
        logic lk;
        if (!port_present[p]) continue;                 // R2
        if (port_admin_up[p] && st_err[p]) continue;    // R8
        lk = port_admin_up[p] ? st_word[p][11] : 1'b0;  // R4 R5
        if (lk == mdl_car[p]) continue;                 // R9
        ep[ne] = PW'(p);
        eb[ne] = lk ? {1'b1, st_word[p][9:8], st_word[p][10], st_word[p][15]} : 5'd0; // R6 R7
        ne++;
        mdl_car[p] = lk;
      end
      base = rec_n;
      run_scan();
      repeat (4) @(negedge clk);
      check("R2 R9 event count", rec_n - base, ne);
      for (int k = 0; k < ne && k < rec_n - base; k++) begin
        check("R2 event port order", rec_port[base + k], ep[k]);
        check("R6 R7 event fields", rec_bits[base + k], eb[k]);
      end
      check("R8 R10 carrier state", carrier, mdl_car);
      check("R2 idle after pass", busy, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule